// File: doc/BRIEF.md
# Shared Fly-By DMA Controller

This block is a direct-memory-access engine that several peripherals share. Each channel holds its own memory pointer, remaining byte count, direction and enable flag. A peripheral that wants service raises its request line. The controller picks one requesting channel and asks the system bus for mastership. Once it holds the bus, it drives the channel's memory address together with a read or a write strobe. In that same cycle it pulses the channel's acknowledge line. The peripheral then places its data word on the data bus, or captures it, without ever decoding the address. This is a fly-by transfer: the word moves between memory and the peripheral in one bus cycle, and it never passes through the controller.

After every word, the controller advances the pointer by one word, reduces the count by one word and gives up the bus, so other masters get a turn. When a channel's count runs out, its completion flag sets and the channel disables itself. A completion flag whose interrupt enable is set raises the interrupt line. Software programs a channel through a simple write port in this order: pointer, count, then a control write that sets the enable. A global write selects either fixed-priority or rotating arbitration.

Top module: `flyby_dma_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `bus_req`, `dma_ack`, `bus_rd`, `bus_wr`, `bus_addr`, `done_flags` and `irq` are all zero.
- R2: A write with `cfg_wr_en` high updates one field of the channel named by `cfg_ch`. Field code 0 sets the memory pointer. Code 1 sets the byte count. Code 2 is the control write: bit 0 is enable, bit 1 is direction (1 means peripheral-to-memory with a bus write, 0 means memory-to-peripheral with a bus read), and a 1 in bit 2 clears that channel's completion flag. Code 3 is global and ignores `cfg_ch`: bit 0 selects rotating arbitration, and bits 4 upward hold the per-channel interrupt enables. A channel is eligible only when it is enabled, its request is high and its count is nonzero.
- R3: `bus_req` rises in the cycle after the idle controller sees an eligible channel. It stays high until the transfer cycle ends. The transfer cycle begins in the cycle after `bus_gnt` is sampled high.
- R4: A transfer cycle lasts exactly one clock. In it, `dma_ack` is one-hot on the chosen channel, `bus_addr` carries that channel's pointer, exactly one of `bus_rd` and `bus_wr` is high according to the direction bit, and `bus_gnt` is high. Outside transfer cycles, `dma_ack`, `bus_rd`, `bus_wr` and `bus_addr` are zero.
- R5: Each transfer adds 4 to the channel's pointer and subtracts 4 from its count. The count must be programmed as a multiple of 4.
- R6: After every transfer, `bus_req` is low for at least one cycle.
- R7: The transfer that brings the count to zero sets the channel's completion flag and clears its enable. Further requests on that channel then have no effect until the enable is written again.
- R8: `irq` is the OR of the completion flags whose interrupt enable is set. Clearing a flag through the control write drops its contribution.
- R9: In fixed mode, the eligible channel with the lowest index wins.
- R10: In rotating mode, the search starts at the channel after the one served last, and wraps from the highest channel to channel 0.
- R11: A request from a channel whose enable is clear raises no bus request and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_ch | input | CH_W | Channel that the write targets |
| cfg_field | input | 2 | Field code of the write |
| cfg_wdata | input | 32 | Write data |
| dma_req | input | NUM_CH | Per-channel peripheral request |
| dma_ack | output | NUM_CH | Per-channel acknowledge, high during that channel's transfer cycle |
| bus_req | output | 1 | Bus mastership request |
| bus_gnt | input | 1 | Bus mastership grant |
| bus_addr | output | ADDR_W | Memory address during a transfer |
| bus_rd | output | 1 | Memory read strobe |
| bus_wr | output | 1 | Memory write strobe |
| done_flags | output | NUM_CH | Per-channel completion flags |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: four channels, a 32-bit pointer and a 16-bit count. With four channels, a rotating sweep crosses the wrap from channel 3 back to channel 0, and a fixed-priority sweep shows a channel that keeps requesting hold off every higher-numbered channel. The bench grant model runs with a grant latency of 0, 1 and 3 cycles. This covers a grant that arrives in the first request cycle as well as a delayed one, and in every case the one-cycle release gap between words stays visible.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;

    // Bytes moved by one transfer on the 32-bit data bus.
    localparam int WORD_BYTES = 4;
    // Width of the configuration write data.
    localparam int CFG_W = 32;

    // Control-field bit positions.
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_DIR_BIT = 1;
    localparam int CTRL_CLR_BIT = 2;

    // Global-field bit positions.
    localparam int GLB_RR_BIT   = 0;
    localparam int GLB_MASK_LSB = 4;

    typedef enum logic [1:0] {
        FLD_ADDR   = 2'd0,
        FLD_COUNT  = 2'd1,
        FLD_CTRL   = 2'd2,
        FLD_GLOBAL = 2'd3
    } cfg_field_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_XFER = 2'd2
    } xfer_state_e;

    // Per-channel flag bundle.
    typedef struct packed {
        logic en;
        logic dir;
        logic done;
    } chan_flags_t;

    // Index width that stays legal for a single channel.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import flyby_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  cfg_field_e        wr_field,
    input  logic [CFG_W-1:0]  wr_data,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  cnt,
    output chan_flags_t       flags
);

    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_BYTES);
    localparam logic [CNT_W-1:0]  CNT_STEP  = CNT_W'(WORD_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '0;
            cnt   <= '0;
            flags <= '0;
        end else begin
            if (wr_hit) begin
                unique case (wr_field)
                    FLD_ADDR:  addr <= ADDR_W'(wr_data);
                    FLD_COUNT: cnt  <= CNT_W'(wr_data);
                    FLD_CTRL: begin
                        flags.en  <= wr_data[CTRL_EN_BIT];
                        flags.dir <= wr_data[CTRL_DIR_BIT];
                        if (wr_data[CTRL_CLR_BIT]) begin
                            flags.done <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
            // A transfer update takes precedence over a software write
            // in the same cycle.
            if (step) begin
                addr <= addr + ADDR_STEP;
                if (cnt <= CNT_STEP) begin
                    cnt        <= '0;
                    flags.done <= 1'b1;
                    flags.en   <= 1'b0;
                end else begin
                    cnt <= cnt - CNT_STEP;
                end
            end
        end
    end

endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rr_mode,
    input  logic [NUM_CH-1:0] elig,
    input  logic              take,
    output logic [CH_W-1:0]   pick,
    output logic              any
);

    localparam logic [CH_W-1:0] LAST_IDX = CH_W'(NUM_CH - 1);

    logic [CH_W-1:0] ptr;

    always_comb begin : pick_logic
        int  j;
        logic found;
        pick  = '0;
        found = 1'b0;
        j     = 0;
        any   = |elig;
        if (!rr_mode) begin
            // Descending scan: the lowest eligible index is written last.
            for (int i = NUM_CH - 1; i >= 0; i--) begin
                if (elig[i]) begin
                    pick = CH_W'(i);
                end
            end
        end else begin
            for (int k = 0; k < NUM_CH; k++) begin
                j = (int'(ptr) + k) % NUM_CH;
                if (!found && elig[j]) begin
                    found = 1'b1;
                    pick  = CH_W'(j);
                end
            end
        end
    end

    // The rotation pointer tracks the channel after the last one picked.
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (take) begin
            ptr <= (pick == LAST_IDX) ? '0 : pick + CH_W'(1);
        end
    end

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import flyby_dma_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              any,
    input  logic [CH_W-1:0]   pick,
    input  logic              bus_gnt,
    output xfer_state_e       state,
    output logic [CH_W-1:0]   sel,
    output logic              take,
    output logic [NUM_CH-1:0] step_vec
);

    xfer_state_e state_nx;

    assign take = (state == ST_IDLE) && any;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (any)     state_nx = ST_ARB;
            ST_ARB:  if (bus_gnt) state_nx = ST_XFER;
            ST_XFER:              state_nx = ST_IDLE;
            default:              state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            sel   <= '0;
        end else begin
            state <= state_nx;
            if (take) begin
                sel <= pick;
            end
        end
    end

    always_comb begin
        step_vec = '0;
        if (state == ST_XFER) begin
            step_vec[sel] = 1'b1;
        end
    end

endmodule

// File: rtl/flyby_dma_ctrl.sv
module flyby_dma_ctrl
    import flyby_dma_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int CH_W   = idx_width(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [1:0]        cfg_field,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [NUM_CH-1:0] dma_req,
    output logic [NUM_CH-1:0] dma_ack,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [NUM_CH-1:0] done_flags,
    output logic              irq
);

    cfg_field_e        field;
    logic              rr_mode;
    logic [NUM_CH-1:0] irq_mask;
    logic [NUM_CH-1:0] elig;
    logic [NUM_CH-1:0] step_vec;
    logic [CH_W-1:0]   pick;
    logic [CH_W-1:0]   sel;
    logic              any;
    logic              take;
    xfer_state_e       state;

    logic [ADDR_W-1:0] ch_addr  [NUM_CH];
    logic [CNT_W-1:0]  ch_cnt   [NUM_CH];
    chan_flags_t       ch_flags [NUM_CH];

    assign field = cfg_field_e'(cfg_field);

    // Global settings: arbitration mode and interrupt enables.
    always_ff @(posedge clk) begin
        if (rst) begin
            rr_mode  <= 1'b0;
            irq_mask <= '0;
        end else if (cfg_wr_en && field == FLD_GLOBAL) begin
            rr_mode  <= cfg_wdata[GLB_RR_BIT];
            irq_mask <= cfg_wdata[GLB_MASK_LSB +: NUM_CH];
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic hit;
        assign hit = cfg_wr_en && (field != FLD_GLOBAL) && (cfg_ch == CH_W'(g));

        dma_chan_regs #(
            .ADDR_W(ADDR_W),
            .CNT_W (CNT_W)
        ) u_regs (
            .clk     (clk),
            .rst     (rst),
            .wr_hit  (hit),
            .wr_field(field),
            .wr_data (cfg_wdata),
            .step    (step_vec[g]),
            .addr    (ch_addr[g]),
            .cnt     (ch_cnt[g]),
            .flags   (ch_flags[g])
        );

        assign elig[g]       = ch_flags[g].en && dma_req[g] && (ch_cnt[g] != '0);
        assign done_flags[g] = ch_flags[g].done;
    end

    dma_arbiter #(
        .NUM_CH(NUM_CH),
        .CH_W  (CH_W)
    ) u_arb (
        .clk    (clk),
        .rst    (rst),
        .rr_mode(rr_mode),
        .elig   (elig),
        .take   (take),
        .pick   (pick),
        .any    (any)
    );

    dma_xfer_fsm #(
        .NUM_CH(NUM_CH),
        .CH_W  (CH_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .any     (any),
        .pick    (pick),
        .bus_gnt (bus_gnt),
        .state   (state),
        .sel     (sel),
        .take    (take),
        .step_vec(step_vec)
    );

    assign bus_req = (state != ST_IDLE);
    assign dma_ack = step_vec;

    always_comb begin
        bus_addr = '0;
        bus_rd   = 1'b0;
        bus_wr   = 1'b0;
        if (state == ST_XFER) begin
            bus_addr = ch_addr[sel];
            bus_rd   = !ch_flags[sel].dir;
            bus_wr   = ch_flags[sel].dir;
        end
    end

    assign irq = |(done_flags & irq_mask);

endmodule

// File: rtl/dma_flyby_checker.sv
module dma_flyby_checker #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] dma_ack,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [NUM_CH-1:0] done_flags,
    input logic              irq
);

    p_ack_under_gnt_r4: assert property (@(posedge clk) disable iff (rst)
        (|dma_ack) |-> bus_gnt);

    p_ack_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dma_ack));

    p_single_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        (|dma_ack) |=> !(|dma_ack));

    p_strobe_with_ack_r4: assert property (@(posedge clk) disable iff (rst)
        (|dma_ack) |-> (bus_rd ^ bus_wr));

    p_no_strobe_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !(|dma_ack) |-> (!bus_rd && !bus_wr));

    p_req_during_xfer_r3: assert property (@(posedge clk) disable iff (rst)
        (|dma_ack) |-> bus_req);

    p_release_after_xfer_r6: assert property (@(posedge clk) disable iff (rst)
        (|dma_ack) |=> !bus_req);

    p_irq_needs_done_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|done_flags));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_done
        p_done_from_xfer_r7: assert property (@(posedge clk) disable iff (rst)
            $rose(done_flags[g]) |-> $past(dma_ack[g]));
    end

endmodule

bind flyby_dma_ctrl dma_flyby_checker #(
    .NUM_CH(NUM_CH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dma_ack   (dma_ack),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .done_flags(done_flags),
    .irq       (irq)
);

// File: tb/flyby_dma_ctrl_test.sv
module flyby_dma_ctrl_test;

    localparam int NUM_CH = 4;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int CH_W   = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_wr_en = 1'b0;
    logic [CH_W-1:0]   cfg_ch = '0;
    logic [1:0]        cfg_field = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [NUM_CH-1:0] dma_req = '0;
    logic [NUM_CH-1:0] dma_ack;
    logic              bus_req;
    logic              bus_gnt = 1'b0;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_rd;
    logic              bus_wr;
    logic [NUM_CH-1:0] done_flags;
    logic              irq;

    always #5 clk = ~clk;

    flyby_dma_ctrl #(
        .NUM_CH(NUM_CH),
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr_en (cfg_wr_en),
        .cfg_ch    (cfg_ch),
        .cfg_field (cfg_field),
        .cfg_wdata (cfg_wdata),
        .dma_req   (dma_req),
        .dma_ack   (dma_ack),
        .bus_req   (bus_req),
        .bus_gnt   (bus_gnt),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .done_flags(done_flags),
        .irq       (irq)
    );

    int checks = 0;
    int errors = 0;

    // Reference model state.
    int          m_phase;          // 0 idle, 1 waiting for grant, 2 moving a word
    int          m_sel;
    int          m_ptr;
    logic [31:0] m_addr [NUM_CH];
    int          m_cnt  [NUM_CH];
    bit          m_en   [NUM_CH];
    bit          m_dir  [NUM_CH];
    bit          m_done [NUM_CH];
    bit          m_mask [NUM_CH];
    bit          m_rr;
    int          run;

    // Peripheral and bus-grant stimulus.
    int          served [NUM_CH];   // written by the model process only
    int          total  [NUM_CH];   // written by the scenario only
    int          gnt_lat = 1;

    // Log of what the design actually served.
    int          order    [$];
    logic [31:0] addr_log [$];

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Per-cycle comparison, stimulus and model step, all at the falling edge.
    always @(negedge clk) begin
        if (rst) begin
            m_phase = 0; m_sel = 0; m_ptr = 0; m_rr = 0; run = 0;
            for (int i = 0; i < NUM_CH; i++) begin
                m_addr[i] = '0; m_cnt[i] = 0; m_en[i] = 0; m_dir[i] = 0;
                m_done[i] = 0; m_mask[i] = 0; served[i] = 0;
            end
            bus_gnt = 1'b0;
            dma_req = '0;
        end else begin
            logic [NUM_CH-1:0] e_ack;
            logic [NUM_CH-1:0] e_done;
            logic [31:0]       e_addr;
            bit                e_rd, e_wr, e_irq, gnt;
            int                pick, old_phase;

            e_ack = '0; e_addr = '0; e_rd = 0; e_wr = 0; e_irq = 0; e_done = '0;
            if (m_phase == 2) begin
                e_ack[m_sel] = 1'b1;
                e_addr       = m_addr[m_sel];
                e_rd         = !m_dir[m_sel];
                e_wr         = m_dir[m_sel];
            end
            for (int i = 0; i < NUM_CH; i++) begin
                e_done[i] = m_done[i];
                if (m_done[i] && m_mask[i]) e_irq = 1;
            end

            chk(bus_req == (m_phase != 0), "R3 R6", "bus_req", longint'(bus_req), longint'(m_phase != 0));
            chk(dma_ack == e_ack, "R4 R9 R10 R11", "dma_ack", longint'(dma_ack), longint'(e_ack));
            chk(bus_rd == e_rd && bus_wr == e_wr, "R4", "rd/wr",
                longint'({bus_rd, bus_wr}), longint'({e_rd, e_wr}));
            chk(bus_addr == e_addr, "R5", "bus_addr", longint'(bus_addr), longint'(e_addr));
            chk(done_flags == e_done, "R7", "done_flags", longint'(done_flags), longint'(e_done));
            chk(irq == e_irq, "R8", "irq", longint'(irq), longint'(e_irq));

            for (int i = 0; i < NUM_CH; i++) begin
                if (dma_ack[i]) begin
                    order.push_back(i);
                    addr_log.push_back(bus_addr);
                end
            end

            // Inputs for this cycle.
            gnt = (m_phase != 0) && (run >= gnt_lat);
            run = (m_phase != 0) ? run + 1 : 0;
            bus_gnt = gnt;
            for (int i = 0; i < NUM_CH; i++) dma_req[i] = (total[i] > served[i]);

            // Arbitration decision from the state before this cycle's writes.
            pick = -1;
            if (m_phase == 0) begin
                if (!m_rr) begin
                    for (int i = NUM_CH - 1; i >= 0; i--)
                        if (m_en[i] && dma_req[i] && m_cnt[i] != 0) pick = i;
                end else begin
                    for (int k = 0; k < NUM_CH; k++) begin
                        int j;
                        j = (m_ptr + k) % NUM_CH;
                        if (pick < 0 && m_en[j] && dma_req[j] && m_cnt[j] != 0) pick = j;
                    end
                end
            end

            // Register write.
            if (cfg_wr_en) begin
                if (cfg_field == 2'd3) begin
                    m_rr = cfg_wdata[0];
                    for (int i = 0; i < NUM_CH; i++) m_mask[i] = cfg_wdata[4 + i];
                end else begin
                    int c;
                    c = int'(cfg_ch);
                    if (cfg_field == 2'd0) m_addr[c] = cfg_wdata;
                    if (cfg_field == 2'd1) m_cnt[c] = int'(cfg_wdata[CNT_W-1:0]);
                    if (cfg_field == 2'd2) begin
                        m_en[c]  = cfg_wdata[0];
                        m_dir[c] = cfg_wdata[1];
                        if (cfg_wdata[2]) m_done[c] = 0;
                    end
                end
            end

            // Word transfer effects, then phase advance.
            old_phase = m_phase;
            if (old_phase == 2) begin
                m_addr[m_sel] = m_addr[m_sel] + 32'd4;
                if (m_cnt[m_sel] <= 4) begin
                    m_cnt[m_sel]  = 0;
                    m_done[m_sel] = 1;
                    m_en[m_sel]   = 0;
                end else begin
                    m_cnt[m_sel] = m_cnt[m_sel] - 4;
                end
                served[m_sel] = served[m_sel] + 1;
                m_phase = 0;
            end else if (old_phase == 1) begin
                if (gnt) m_phase = 2;
            end else if (pick >= 0) begin
                m_phase = 1;
                m_sel   = pick;
                m_ptr   = (pick + 1) % NUM_CH;
            end
        end
    end

    task automatic cfg_write(input int ch, input int fld, input logic [31:0] data);
        @(posedge clk); #1;
        cfg_wr_en = 1'b1;
        cfg_ch    = CH_W'(ch);
        cfg_field = 2'(fld);
        cfg_wdata = data;
        @(posedge clk); #1;
        cfg_wr_en = 1'b0;
    endtask

    task automatic wait_quiet();
        int quiet;
        quiet = 0;
        for (int n = 0; n < 3000; n++) begin
            bit busy;
            @(posedge clk); #1;
            busy = (m_phase != 0);
            for (int i = 0; i < NUM_CH; i++)
                if (served[i] < total[i] && m_en[i] && m_cnt[i] != 0) busy = 1;
            quiet = busy ? 0 : quiet + 1;
            if (quiet >= 4) break;
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog run did not finish");
        summary();
        $finish;
    end

    initial begin
        int base;
        for (int i = 0; i < NUM_CH; i++) total[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        // R1: idle outputs right after reset.
        chk(!bus_req && dma_ack == '0 && !bus_rd && !bus_wr && bus_addr == '0 &&
            done_flags == '0 && !irq, "R1", "reset outputs",
            longint'({bus_req, dma_ack, done_flags, irq}), 0);

        // R11 and R2: a programmed but disabled channel is ignored.
        gnt_lat = 1;
        cfg_write(1, 0, 32'h0000_1000);
        cfg_write(1, 1, 32'd8);
        cfg_write(1, 2, 32'h2);
        total[1] = 2;
        repeat (12) @(posedge clk);
        #1 chk(order.size() == 0 && !bus_req, "R11", "served while disabled",
               longint'(order.size()), 0);

        // R2: set the enable last, and the channel runs to completion.
        cfg_write(1, 2, 32'h3);
        wait_quiet();
        chk(order.size() == 2 && order[0] == 1 && order[1] == 1, "R2", "channel 1 words",
            longint'(order.size()), 2);
        chk(addr_log.size() == 2 && addr_log[1] == 32'h1004, "R5", "second pointer",
            longint'(addr_log.size() == 2 ? addr_log[1] : 32'h0), 32'h1004);
        chk(done_flags == 4'b0010 && !irq, "R7 R8", "done without enable",
            longint'({done_flags, irq}), longint'({4'b0010, 1'b0}));

        // R7: after completion, further requests are ignored.
        total[1] = 3;
        repeat (12) @(posedge clk);
        #1 chk(order.size() == 2, "R7", "served after completion", longint'(order.size()), 2);
        total[1] = 2;

        // R8: enable the interrupt, then clear the flag.
        cfg_write(0, 3, 32'h0000_00F0);
        #1 chk(irq == 1'b1, "R8", "irq after unmask", longint'(irq), 1);
        cfg_write(1, 2, 32'h4);
        #1 chk(irq == 1'b0 && done_flags == '0, "R8", "irq after clear",
               longint'({done_flags, irq}), 0);

        // R2: an enabled channel with a zero count is never eligible.
        cfg_write(2, 1, 32'd0);
        cfg_write(2, 2, 32'h1);
        total[2] = 1;
        repeat (12) @(posedge clk);
        #1 chk(order.size() == 2 && !bus_req, "R2", "zero count served",
               longint'(order.size()), 2);
        total[2] = 0;
        cfg_write(2, 2, 32'h0);

        // R9: fixed priority with an immediate grant.
        gnt_lat = 0;
        for (int i = 0; i < NUM_CH; i++) begin
            cfg_write(i, 0, 32'h2000 + 32'(i) * 32'h100);
            cfg_write(i, 1, 32'd8);
            cfg_write(i, 2, 32'h1 | (32'(i % 2) << 1));
        end
        base = order.size();
        @(posedge clk); #1;
        for (int i = 0; i < NUM_CH; i++) total[i] = total[i] + 2;
        wait_quiet();
        chk(order.size() == base + 8, "R9", "fixed word count", longint'(order.size() - base), 8);
        if (order.size() == base + 8) begin
            for (int k = 0; k < 8; k++)
                chk(order[base + k] == k / 2, "R9", "fixed order",
                    longint'(order[base + k]), longint'(k / 2));
            chk(addr_log[base + 1] == 32'h2004, "R5", "channel 0 pointer step",
                longint'(addr_log[base + 1]), 32'h2004);
        end
        chk(done_flags == 4'hF && irq, "R7 R8", "all done",
            longint'({done_flags, irq}), longint'({4'hF, 1'b1}));

        // R10: rotating order with a slow grant.
        gnt_lat = 3;
        cfg_write(0, 3, 32'h0000_00F1);
        for (int i = 0; i < NUM_CH; i++) begin
            cfg_write(i, 0, 32'h3000 + 32'(i) * 32'h40);
            cfg_write(i, 1, 32'd8);
            cfg_write(i, 2, 32'h5);
        end
        #1 chk(done_flags == '0 && !irq, "R8", "cleared before rotation",
               longint'({done_flags, irq}), 0);
        base = order.size();
        @(posedge clk); #1;
        for (int i = 0; i < NUM_CH; i++) total[i] = total[i] + 2;
        wait_quiet();
        chk(order.size() == base + 8, "R10", "rotating word count",
            longint'(order.size() - base), 8);
        if (order.size() == base + 8) begin
            for (int k = 0; k < 8; k++)
                chk(order[base + k] == k % 4, "R10", "rotating order",
                    longint'(order[base + k]), longint'(k % 4));
        end
        chk(done_flags == 4'hF && irq, "R7 R8", "all done after rotation",
            longint'({done_flags, irq}), longint'({4'hF, 1'b1}));

        repeat (4) @(posedge clk);
        summary();
        $finish;
    end

endmodule